// File: doc/BRIEF.md
# SD Command Line Issuer with Response Capture

This block drives the command wire of an SD/MMC card and collects the card's answer. It handles one command at a time. Software first loads a 32-bit argument and then writes a 16-bit command word. That second write launches the command. The block serialises a 48-bit frame, protected by CRC7, onto the command wire at one bit per clock. Depending on the response type, it then either finishes at once or listens for a 48-bit or 136-bit reply from the card.

A reply can be checked against its CRC7, against the command index, or both, and a mismatch raises an error flag. If the card stays silent, a timeout flag is raised instead. Either way, a completion flag marks the end of the command. Two inhibit flags tell software when the block is free. The first covers the command in flight. The second covers data-line occupancy: it is set by a busy-type or data-carrying command and is held until DAT0 reads high again. The four data-line levels are mirrored for software to read. A self-clearing reset-all control returns the whole engine to idle.

A long reply is stored without its CRC byte. The 120 content bits therefore land in the low bits of the 128-bit response, and software must shift them back into place.

Top module: `sdcmd_engine`

## Requirements
- R1: An accepted command word produces 48 bits on `cmd_out` with `cmd_oe` high, most significant bit first, starting the cycle after the write. The bits are: a 0, a 1, the index from word bits [13:8], the stored argument, the CRC7 (polynomial x^7+x^3+1) over the previous 40 bits, and a closing 1.
- R2: A command write that arrives while `inhibit_cmd` is high is ignored. It launches no frame and leaves the frame in progress unchanged.
- R3: Response type is word bits [1:0]: 00 none, 01 136-bit, 10 48-bit, 11 48-bit followed by busy. With type 00, `sts_complete` rises within a few cycles of the last frame bit, and no timeout is reported.
- R4: For a 48-bit reply, `resp[31:0]` holds reply bits [39:8] and `resp[127:32]` is zero.
- R5: For a 136-bit reply, `resp` holds reply bits [127:8] in its low 120 bits, and its top 8 bits are zero.
- R6: When word bit 3 is set, a reply whose CRC7 does not match its content sets `sts_error`. When bit 3 is clear, no CRC error is raised.
- R7: When word bit 4 is set, a 48-bit reply whose index field (bits [45:40]) differs from the issued index sets `sts_error`.
- R8: If the card drives no start bit within 64 cycles after the frame, `sts_timeout` and `sts_complete` are set. A start bit 55 cycles after the frame raises no timeout.
- R9: `inhibit_cmd` is high from acceptance until completion. For type 11, or when the data-present bit (word bit 5) is set, `inhibit_dat` stays high after completion until `dat_in[0]` is high.
- R10: `dat_level` always equals `dat_in`.
- R11: Writing `sts_clr_mask` with `sts_clr_we` clears each flag whose bit is 1: bit 0 complete, bit 1 timeout, bit 2 error. Flags whose bit is 0 are kept.
- R12: A pulse on `rst_all_we` raises `reset_busy`. `reset_busy` drops by itself after 4 cycles, and afterwards the status flags, the inhibits and `resp` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command-wire bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_we | input | 1 | Load argument register |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Write command word, launching a command |
| cmd_wdata | input | 16 | Command word (index, check enables, response type) |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for the status flags |
| sts_clr_mask | input | 3 | Flags to clear: complete, timeout, error |
| rst_all_we | input | 1 | Start a reset of the whole engine |
| cmd_in | input | 1 | Command wire level driven by the card |
| dat_in | input | 4 | Data wire levels |
| cmd_out | output | 1 | Command wire value driven by the host |
| cmd_oe | output | 1 | Host drives the command wire |
| inhibit_cmd | output | 1 | Command in flight |
| inhibit_dat | output | 1 | Data wires held by a busy or data command |
| dat_level | output | 4 | Mirror of the data wires |
| sts_complete | output | 1 | Command finished |
| sts_timeout | output | 1 | No reply start bit seen |
| sts_error | output | 1 | CRC or index mismatch |
| resp | output | 128 | Captured reply |
| reset_busy | output | 1 | Reset-all still in progress |

## Verification
On every cycle, the in-module assertions check the following: the host drives the wire only while a command is inhibiting, every frame opens with a 0, a launch never lands on a frame already being shifted, a reply is never both captured and timed out, completion always releases the command inhibit, and a reset request raises the reset flag. The bench scenarios are needed for everything that depends on content and timing: the exact frame bits and CRC7, the alignment of short and long replies, error detection for CRC and index, the timeout window around 64 cycles, the release of busy on DAT0, and the selective clearing of status bits.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [1:0] {
        RESP_NONE       = 2'b00,
        RESP_LONG       = 2'b01,
        RESP_SHORT      = 2'b10,
        RESP_SHORT_BUSY = 2'b11
    } resp_kind_e;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_of40(input logic [39:0] v);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
        return c;
    endfunction

    function automatic logic [6:0] crc7_of120(input logic [119:0] v);
        logic [6:0] c;
        c = '0;
        for (int i = 119; i >= 0; i--) c = crc7_step(c, v[i]);
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_frame_tx.sv
module sdcmd_frame_tx
    import sdcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        start,
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    output logic        line_out,
    output logic        line_oe,
    output logic        last_bit
);
    localparam int CW = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [CW-1:0]         cnt;
        logic                  act;
    } tx_s;

    tx_s tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        if (clear) begin
            tx_d = '0;
        end else if (start) begin
            tx_d.sh  = {2'b01, idx, arg, crc7_of40({2'b01, idx, arg}), 1'b1};
            tx_d.cnt = CW'(FRAME_BITS - 1);
            tx_d.act = 1'b1;
        end else if (tx_q.act) begin
            tx_d.sh = {tx_q.sh[FRAME_BITS-2:0], 1'b1};
            if (tx_q.cnt == '0) tx_d.act = 1'b0;
            else                tx_d.cnt = tx_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign line_oe  = tx_q.act;
    assign line_out = tx_q.act ? tx_q.sh[FRAME_BITS-1] : 1'b1;
    assign last_bit = tx_q.act && (tx_q.cnt == '0);

    // R1: every frame opens with a zero start bit
    assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !line_out);
    // R2: the controller never launches over a frame in progress
    assert_no_relaunch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !line_oe);

endmodule

// File: rtl/sdcmd_resp_rx.sv
module sdcmd_resp_rx
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 arm,
    input  logic                 long_rsp,
    input  logic                 line_in,
    output logic                 got,
    output logic                 timed_out,
    output logic [LONG_BITS-1:0] frame
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_st_e;

    typedef struct packed {
        rx_st_e               st;
        logic [LONG_BITS-1:0] sh;
        logic [7:0]           cnt;
        logic [TW-1:0]        tmo;
        logic                 lng;
        logic                 got;
        logic                 tmo_hit;
    } rx_s;

    rx_s rx_q, rx_d;

    always_comb begin
        rx_d         = rx_q;
        rx_d.got     = 1'b0;
        rx_d.tmo_hit = 1'b0;
        if (clear) begin
            rx_d = '0;
        end else begin
            case (rx_q.st)
                RX_IDLE: if (arm) begin
                    rx_d.st  = RX_WAIT;
                    rx_d.tmo = '0;
                    rx_d.lng = long_rsp;
                    rx_d.sh  = '0;
                end
                RX_WAIT: if (!line_in) begin
                    rx_d.sh  = {rx_q.sh[LONG_BITS-2:0], 1'b0};
                    rx_d.cnt = rx_q.lng ? 8'(LONG_BITS - 2) : 8'(FRAME_BITS - 2);
                    rx_d.st  = RX_RECV;
                end else if (rx_q.tmo == TW'(TIMEOUT_CYC - 1)) begin
                    rx_d.tmo_hit = 1'b1;
                    rx_d.st      = RX_IDLE;
                end else begin
                    rx_d.tmo = rx_q.tmo + 1'b1;
                end
                RX_RECV: begin
                    rx_d.sh = {rx_q.sh[LONG_BITS-2:0], line_in};
                    if (rx_q.cnt == 8'd0) begin
                        rx_d.got = 1'b1;
                        rx_d.st  = RX_IDLE;
                    end else begin
                        rx_d.cnt = rx_q.cnt - 8'd1;
                    end
                end
                default: rx_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign got       = rx_q.got;
    assign timed_out = rx_q.tmo_hit;
    assign frame     = rx_q.sh;

    // R8: a reply ends either captured or timed out, never both
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(got && timed_out));
    // R9: the controller arms only an idle receiver
    assert_arm_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> rx_q.st == RX_IDLE);

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int RST_CYCLES  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arg_we,
    input  logic [31:0]  arg_wdata,
    input  logic         cmd_we,
    input  logic [15:0]  cmd_wdata,
    input  logic         sts_clr_we,
    input  logic [2:0]   sts_clr_mask,
    input  logic         rst_all_we,
    input  logic         cmd_in,
    input  logic [3:0]   dat_in,
    output logic         cmd_out,
    output logic         cmd_oe,
    output logic         inhibit_cmd,
    output logic         inhibit_dat,
    output logic [3:0]   dat_level,
    output logic         sts_complete,
    output logic         sts_timeout,
    output logic         sts_error,
    output logic [127:0] resp,
    output logic         reset_busy
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [31:0]  arg;
        logic [5:0]   idx;
        resp_kind_e   rtype;
        logic         crc_en;
        logic         idx_en;
        logic         inh_cmd;
        logic         inh_dat;
        logic         done;
        logic         tmo;
        logic         err;
        logic [127:0] resp;
        logic [RW-1:0] rst_cnt;
        logic         rst_busy;
    } eng_s;

    eng_s eng_q, eng_d;

    logic                 tx_start, tx_last, rx_arm, rx_got, rx_tmo;
    logic [LONG_BITS-1:0] rx_frame;
    logic                 crc_bad, idx_bad;

    always_comb begin
        eng_d    = eng_q;
        tx_start = 1'b0;
        rx_arm   = 1'b0;
        crc_bad  = 1'b0;
        idx_bad  = 1'b0;
        if (eng_q.rst_busy) begin
            eng_d          = '0;
            eng_d.rst_busy = (eng_q.rst_cnt != '0);
            eng_d.rst_cnt  = (eng_q.rst_cnt == '0) ? '0 : eng_q.rst_cnt - 1'b1;
        end else if (rst_all_we) begin
            eng_d.rst_busy = 1'b1;
            eng_d.rst_cnt  = RW'(RST_CYCLES - 1);
        end else begin
            if (sts_clr_we) begin
                if (sts_clr_mask[0]) eng_d.done = 1'b0;
                if (sts_clr_mask[1]) eng_d.tmo  = 1'b0;
                if (sts_clr_mask[2]) eng_d.err  = 1'b0;
            end
            if (arg_we) eng_d.arg = arg_wdata;
            if (eng_q.inh_dat && !eng_q.inh_cmd && dat_in[0]) eng_d.inh_dat = 1'b0;
            if (cmd_we && !eng_q.inh_cmd) begin
                eng_d.idx     = cmd_wdata[13:8];
                eng_d.idx_en  = cmd_wdata[4];
                eng_d.crc_en  = cmd_wdata[3];
                eng_d.rtype   = resp_kind_e'(cmd_wdata[1:0]);
                eng_d.inh_cmd = 1'b1;
                if (cmd_wdata[5] || cmd_wdata[1:0] == 2'b11) eng_d.inh_dat = 1'b1;
                tx_start      = 1'b1;
            end
            if (tx_last) begin
                if (eng_q.rtype == RESP_NONE) begin
                    eng_d.done    = 1'b1;
                    eng_d.inh_cmd = 1'b0;
                end else begin
                    rx_arm = 1'b1;
                end
            end
            if (rx_tmo) begin
                eng_d.done    = 1'b1;
                eng_d.tmo     = 1'b1;
                eng_d.inh_cmd = 1'b0;
            end
            if (rx_got) begin
                if (eng_q.rtype == RESP_LONG) begin
                    eng_d.resp = {8'h00, rx_frame[127:8]};
                    crc_bad    = crc7_of120(rx_frame[127:8]) != rx_frame[7:1];
                end else begin
                    eng_d.resp = {96'h0, rx_frame[39:8]};
                    crc_bad    = crc7_of40(rx_frame[47:8]) != rx_frame[7:1];
                    idx_bad    = rx_frame[45:40] != eng_q.idx;
                end
                eng_d.err     = eng_d.err | (eng_q.crc_en & crc_bad) | (eng_q.idx_en & idx_bad);
                eng_d.done    = 1'b1;
                eng_d.inh_cmd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    sdcmd_frame_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (eng_q.rst_busy),
        .start    (tx_start),
        .idx      (cmd_wdata[13:8]),
        .arg      (eng_q.arg),
        .line_out (cmd_out),
        .line_oe  (cmd_oe),
        .last_bit (tx_last)
    );

    sdcmd_resp_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (eng_q.rst_busy),
        .arm       (rx_arm),
        .long_rsp  (eng_q.rtype == RESP_LONG),
        .line_in   (cmd_in),
        .got       (rx_got),
        .timed_out (rx_tmo),
        .frame     (rx_frame)
    );

    logic unused_bits;
    assign unused_bits = ^{cmd_wdata[15:14], cmd_wdata[7:6], cmd_wdata[2],
                           rx_frame[LONG_BITS-1:128], rx_frame[0]};

    assign inhibit_cmd  = eng_q.inh_cmd;
    assign inhibit_dat  = eng_q.inh_dat;
    assign dat_level    = dat_in;
    assign sts_complete = eng_q.done;
    assign sts_timeout  = eng_q.tmo;
    assign sts_error    = eng_q.err;
    assign resp         = eng_q.resp;
    assign reset_busy   = eng_q.rst_busy;

    // R9: the wire is driven only while a command holds the inhibit
    assert_oe_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> inhibit_cmd);
    // R9: completion always frees the command inhibit
    assert_done_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_complete) |-> !inhibit_cmd);
    // R12: a reset request is visible on the next cycle
    assert_reset_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_all_we && !reset_busy) |=> reset_busy);
    // R12: state stays cleared while the reset runs
    assert_reset_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_busy && $past(reset_busy)) |-> (!inhibit_cmd && !sts_complete));

endmodule

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arg_we = 1'b0, cmd_we = 1'b0, sts_clr_we = 1'b0, rst_all_we = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic [15:0]  cmd_wdata = '0;
    logic [2:0]   sts_clr_mask = '0;
    logic         cmd_in = 1'b1;
    logic [3:0]   dat_in = 4'hF;
    logic         cmd_out, cmd_oe, inhibit_cmd, inhibit_dat, sts_complete, sts_timeout, sts_error, reset_busy;
    logic [3:0]   dat_level;
    logic [127:0] resp;

    int checks = 0, failures = 0, frames_seen = 0;
    bit finished = 0;
    logic [47:0] exp_q[$];

    always #10 clk = ~clk;

    sdcmd_engine uut (
        .clk(clk), .rst_n(rst_n), .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .sts_clr_we(sts_clr_we),
        .sts_clr_mask(sts_clr_mask), .rst_all_we(rst_all_we), .cmd_in(cmd_in),
        .dat_in(dat_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .inhibit_cmd(inhibit_cmd), .inhibit_dat(inhibit_dat), .dat_level(dat_level),
        .sts_complete(sts_complete), .sts_timeout(sts_timeout), .sts_error(sts_error),
        .resp(resp), .reset_busy(reset_busy)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] tb_crc(input logic [119:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic top = c[6] ^ v[i];
            c = {c[5:0], 1'b0};
            if (top) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    function automatic logic [47:0] host_frame(input logic [5:0] idx, input logic [31:0] a);
        return {2'b01, idx, a, tb_crc({80'h0, 2'b01, idx, a}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] short_reply(input logic [5:0] idx, input logic [31:0] p, input bit bad);
        logic [6:0] c = tb_crc({80'h0, 2'b00, idx, p}, 40);
        if (bad) c[0] = ~c[0];
        return {88'h0, 2'b00, idx, p, c, 1'b1};
    endfunction

    // monitor: collects host frames and compares with the scoreboard queue
    logic [47:0] mon_sh;
    int          mon_n = 0;
    always @(negedge clk) begin
        if (cmd_oe) begin
            mon_sh = {mon_sh[46:0], cmd_out};
            mon_n++;
            if (mon_n == 48) begin
                mon_n = 0;
                frames_seen++;
                if (exp_q.size() == 0) chk("R2 unexpected frame", 128'(mon_sh), 128'h0);
                else chk("R1 frame", 128'(mon_sh), 128'(exp_q.pop_front()));
            end
        end
    end

    task automatic issue(input logic [5:0] idx, input logic [31:0] a, input logic [1:0] rt,
                         input bit crc_en, input bit idx_en, input bit dp);
        exp_q.push_back(host_frame(idx, a));
        @(negedge clk); arg_we = 1; arg_wdata = a;
        @(negedge clk); arg_we = 0; cmd_we = 1;
        cmd_wdata = {2'b00, idx, 2'b00, dp, idx_en, crc_en, 1'b0, rt};
        @(negedge clk); cmd_we = 0;
    endtask

    task automatic respond(input logic [135:0] f, input int n, input int gap);
        while (cmd_oe) @(negedge clk);
        repeat (gap) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            cmd_in = f[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !sts_complete; i++) @(negedge clk);
    endtask

    task automatic clear_sts(input logic [2:0] m);
        @(negedge clk); sts_clr_we = 1; sts_clr_mask = m;
        @(negedge clk); sts_clr_we = 0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [119:0] content;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R9 reset inhibit", {inhibit_cmd, inhibit_dat, cmd_oe}, 0);
        chk("R11 reset status", {sts_complete, sts_timeout, sts_error, reset_busy}, 0);
        chk("R4 reset resp", resp, 0);

        // R1/R3: index 0, no reply; frame anchored to a known constant
        exp_q.push_back(48'h400000000095);
        @(negedge clk); arg_we = 1; arg_wdata = 0;
        @(negedge clk); arg_we = 0; cmd_we = 1; cmd_wdata = 16'h0000;
        @(negedge clk); cmd_we = 0;
        chk("R9 inhibit during frame", inhibit_cmd, 1);
        while (cmd_oe) @(negedge clk);
        wait_done(3);
        chk("R3 complete without reply", {sts_complete, sts_timeout}, 2'b10);
        clear_sts(3'b111);

        // R4/R6/R7: short reply, all checks on, valid
        issue(6'd17, 32'h0000_1234, 2'b10, 1, 1, 0);
        respond(short_reply(6'd17, 32'hCAFE_0900, 0), 48, 3);
        wait_done(20);
        chk("R4 short payload", resp, 128'hCAFE_0900);
        chk("R6 R7 no error on good reply", {sts_complete, sts_error, inhibit_cmd}, 3'b100);
        clear_sts(3'b111);

        // R6: bad CRC with check on, then selective clear (R11)
        issue(6'd13, 32'hA5A5_0000, 2'b10, 1, 0, 0);
        respond(short_reply(6'd13, 32'h0000_0ABC, 1), 48, 2);
        wait_done(20);
        chk("R6 crc error flagged", {sts_complete, sts_error}, 2'b11);
        clear_sts(3'b100);
        chk("R11 only error cleared", {sts_complete, sts_timeout, sts_error}, 3'b100);
        clear_sts(3'b111);
        chk("R11 all cleared", {sts_complete, sts_timeout, sts_error}, 3'b000);

        // R6: bad CRC with check off
        issue(6'd13, 32'h0000_0001, 2'b10, 0, 0, 0);
        respond(short_reply(6'd13, 32'h1111_2222, 1), 48, 0);
        wait_done(20);
        chk("R6 crc ignored when disabled", {sts_complete, sts_error}, 2'b10);
        clear_sts(3'b111);

        // R7: wrong index with index check on
        issue(6'd9, 32'h0000_0055, 2'b10, 0, 1, 0);
        respond(short_reply(6'd18, 32'h3333_4444, 0), 48, 1);
        wait_done(20);
        chk("R7 index mismatch", {sts_complete, sts_error}, 2'b11);
        clear_sts(3'b111);

        // R5: long reply, CRC on
        content = {32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 24'hDDEEF0};
        issue(6'd2, 32'h0, 2'b01, 1, 0, 0);
        respond({2'b00, 6'h3F, content, tb_crc(content, 120), 1'b1}, 136, 4);
        wait_done(20);
        chk("R5 long reply realigned", resp, {8'h00, content});
        chk("R5 long crc ok", {sts_complete, sts_error}, 2'b10);
        clear_sts(3'b111);

        // R8: silent card -> timeout, not early
        issue(6'd3, 32'h0, 2'b10, 0, 0, 0);
        while (cmd_oe) @(negedge clk);
        repeat (58) @(negedge clk);
        chk("R8 no early timeout", {sts_complete, sts_timeout}, 2'b00);
        wait_done(20);
        chk("R8 timeout flagged", {sts_complete, sts_timeout, inhibit_cmd}, 3'b110);
        clear_sts(3'b111);

        // R8: late but in-window start bit
        issue(6'd3, 32'h0000_0777, 2'b10, 0, 0, 0);
        respond(short_reply(6'd3, 32'h0BAD_F00D, 0), 48, 55);
        wait_done(20);
        chk("R8 late reply accepted", {sts_complete, sts_timeout}, 2'b10);
        chk("R8 late reply payload", resp, 128'h0BAD_F00D);
        clear_sts(3'b111);

        // R2: second write during a frame is ignored
        frames_seen = 0;
        issue(6'd13, 32'hDEAD_BEEF, 2'b00, 0, 0, 0);
        repeat (5) @(negedge clk);
        cmd_we = 1; cmd_wdata = 16'h2A00;
        @(negedge clk); cmd_we = 0;
        wait_done(60);
        repeat (60) @(negedge clk);
        chk("R2 single frame", frames_seen, 1);
        chk("R2 wire idle", {cmd_oe, inhibit_cmd}, 2'b00);
        clear_sts(3'b111);

        // R9: busy reply holds data inhibit until DAT0 rises
        dat_in = 4'b1110;
        issue(6'd7, 32'h0000_0001, 2'b11, 1, 1, 0);
        chk("R9 dat inhibit set at issue", inhibit_dat, 1);
        respond(short_reply(6'd7, 32'h0000_0800, 0), 48, 2);
        wait_done(20);
        repeat (5) @(negedge clk);
        chk("R9 dat inhibit held while busy", {sts_complete, inhibit_cmd, inhibit_dat}, 3'b101);
        dat_in = 4'b1111;
        repeat (2) @(negedge clk);
        chk("R9 dat inhibit released", inhibit_dat, 0);

        // R10: data levels mirrored
        dat_in = 4'b0110;
        @(negedge clk);
        chk("R10 dat mirror", dat_level, 4'b0110);
        dat_in = 4'hF;

        // R12: reset-all with status and response present
        @(negedge clk); rst_all_we = 1;
        @(negedge clk); rst_all_we = 0;
        chk("R12 reset flag set", reset_busy, 1);
        repeat (4) @(negedge clk);
        chk("R12 reset self-clears", reset_busy, 0);
        chk("R12 state cleared", {sts_complete, sts_timeout, sts_error, inhibit_cmd, inhibit_dat}, 0);
        chk("R12 resp cleared", resp, 0);

        summary();
    end

endmodule